// File: doc/BRIEF.md
# Command Queue Doorbell and Fetch Sequencer

This block runs one memory-resident command queue. Software rings a doorbell with a count of 64-bit words it has appended. The block adds that count to a pending-word counter. While the queue is enabled and at least one whole 8-word instruction is pending, it requests 64-byte instruction lines from memory over a valid/ready request channel with a separate response channel. Only one read is outstanding at a time.

The command buffer is a chain of segments. Each segment holds a programmed number of instructions followed by one extra word that points to the next segment. When the instructions of a segment are used up, the sequencer reads that pointer word and continues from the address it returns. A small five-bit event register with mask and an interrupt output records doorbell overflow, read errors, result-write errors, software errors and mailbox events. Unless continue-on-error is set, any error event switches the queue off on its own. An 8-bit in-flight counter tracks issued instructions until an external completion pulse retires them. Segment size and start address can be changed only while the queue is quiescent.

Top module: `cmdq_fetch_seq`

## Requirements
- R1: After a synchronous active-high reset the queue is disabled, continue-on-error is 0, and the pending count, in-flight count, event status, event mask, segment size and fetch address are all 0. No read request is raised and irq is low.
- R2: A write with reg_sel=1 adds reg_wdata[19:0] to pending_words. Every accepted instruction request subtracts 8 from it. A doorbell add and a subtraction in the same cycle both take effect.
- R3: An instruction request (rd_req_ptr=0) starts only while q_enable=1, pending_words>=8 and inflight<255. Its rd_req_addr is the current 64-byte line address, and fetch_addr advances by one line when the request is accepted.
- R4: With segment size S words (reg_sel=2, bits 12:0), n=(S-1)/8. After n instructions in a segment, the next request is a pointer request (rd_req_ptr=1) at the line that follows the last instruction. A good response loads fetch_addr with rd_rsp_ptr and starts a new segment.
- R5: If a doorbell add takes the pending count past 2^20-1, the count keeps the low 20 bits of the sum and status bit 1 (doorbell overflow) is set.
- R6: Status bits are: bit 0 mailbox, bit 1 doorbell overflow, bit 2 read error, bit 3 result-write error, bit 4 software error. reg_sel=4 clears the bits written with 1 and reg_sel=5 sets them. reg_sel=6 sets mask bits and reg_sel=7 clears them. A hardware event wins over a clear in the same cycle. irq is the OR of status AND mask.
- R7: With continue-on-error=0, setting status bit 1, 2 or 3 (by hardware or by reg_sel=5) clears q_enable at the same edge. Bits 0 and 4 never do this. With continue-on-error=1 the queue stays enabled. reg_sel=0 writes enable (bit 0) and continue-on-error (bit 1).
- R8: An error response sets status bit 2. For an instruction read it also lowers inflight by one. For a pointer read it leaves fetch_addr unchanged, so the pointer is read again later.
- R9: inflight rises by one per accepted instruction request and falls by one per inst_done pulse. A pulse while it is 0 has no effect.
- R10: Writes to segment size (reg_sel=2) and start address (reg_sel=3, bits 42:0) take effect only while q_enable=0, inflight=0 and no read is outstanding. Otherwise they are ignored.
- R11: Once raised, rd_req_valid stays high, and rd_req_addr and rd_req_ptr stay stable, until rd_req_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select for the write |
| reg_wdata | input | 43 | Write data |
| hw_mbox | input | 1 | Mailbox event pulse |
| hw_nwrp | input | 1 | Result-write error pulse |
| hw_swerr | input | 1 | Software error pulse from engines |
| inst_done | input | 1 | Instruction completion pulse |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 43 | 64-byte line address of the read |
| rd_req_ptr | output | 1 | Read is for a next-segment pointer |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_err | input | 1 | Read response carries an error |
| rd_rsp_ptr | input | 43 | Next-segment line address (pointer reads) |
| q_enable | output | 1 | Queue enable |
| cont_on_err | output | 1 | Continue-on-error setting |
| pending_words | output | 20 | Pending doorbell word count |
| fetch_addr | output | 43 | Next fetch line address |
| seg_words | output | 13 | Segment size in words |
| inflight | output | 8 | Instructions in flight |
| int_status | output | 5 | Event status bits |
| int_mask | output | 5 | Event mask bits |
| irq | output | 1 | Masked event interrupt |

## Verification
The bench aims at four places where a design can go wrong.

- **Segment boundary.** A sequencer that miscounts n would fetch the pointer word as an instruction, or chase the pointer one line early.
- **Doorbell wrap.** A design that saturates the count, or forgets the overflow flag, leaves a pending count other than 8 after the wrap test.
- **Errors and the enable.** The bench checks that error events drop the enable while mailbox and software-error events do not. It also checks that a hardware event beats a same-cycle clear.
- **Failed pointer read.** After a failed pointer read, a design that still loads the returned pointer, or keeps counting the failed instruction as in flight, shows a wrong fetch_addr or inflight value.

Configuration writes made while the queue is busy must leave fetch_addr and seg_words unchanged.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

    localparam int DEF_ADDR_W = 43;
    localparam int DEF_CNT_W  = 20;
    localparam int DEF_SIZE_W = 13;
    localparam int DEF_INFL_W = 8;
    localparam int INST_WORDS = 8;
    localparam int EVT_W      = 5;

    typedef enum logic [2:0] {
        SEL_CTRL     = 3'd0,
        SEL_DBELL    = 3'd1,
        SEL_SEGSZ    = 3'd2,
        SEL_START    = 3'd3,
        SEL_EVT_CLR  = 3'd4,
        SEL_EVT_SET  = 3'd5,
        SEL_MASK_SET = 3'd6,
        SEL_MASK_CLR = 3'd7
    } reg_sel_e;

    typedef enum logic [2:0] {
        F_IDLE,
        F_INST_REQ,
        F_INST_WAIT,
        F_PTR_REQ,
        F_PTR_WAIT
    } fetch_state_e;

    // bit 4 .. bit 0
    typedef struct packed {
        logic swerr;
        logic nwrp;
        logic irde;
        logic dovf;
        logic mbox;
    } evt_vec_t;

    function automatic int unsigned insts_in_seg(input int unsigned words);
        if (words == 0) return 0;
        return (words - 1) / INST_WORDS;
    endfunction

endpackage

// File: rtl/cmdq_dbell_cnt.sv
module cmdq_dbell_cnt #(
    parameter int CNT_W = cmdq_pkg::DEF_CNT_W,
    parameter int STEP  = cmdq_pkg::INST_WORDS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             add_vld,
    input  logic [CNT_W-1:0] add_val,
    input  logic             take,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);
    localparam logic [CNT_W:0] STEP_V = (CNT_W+1)'(STEP);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   sum;

    always_comb begin
        sum = {1'b0, cnt_q};
        if (take)    sum = sum - STEP_V;
        if (add_vld) sum = sum + {1'b0, add_val};
    end

    assign ovf_o = sum[CNT_W];
    assign cnt_o = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= sum[CNT_W-1:0];
    end

    // R2: an instruction is only taken when a whole one is pending
    a_r2_take_covered: assert property (@(posedge clk) disable iff (rst)
        take |-> (cnt_q >= CNT_W'(STEP)));

    // R5: overflow can only come from a doorbell add
    a_r5_ovf_from_add: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> add_vld);

endmodule

// File: rtl/cmdq_evt_regs.sv
module cmdq_evt_regs
    import cmdq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  evt_vec_t         hw_set,
    input  logic             clr_wr,
    input  logic             set_wr,
    input  logic             mset_wr,
    input  logic             mclr_wr,
    input  logic [EVT_W-1:0] wdata,
    output logic [EVT_W-1:0] stat_o,
    output logic [EVT_W-1:0] mask_o,
    output logic             irq_o,
    output logic             err_set_o
);
    logic [EVT_W-1:0] stat_q, mask_q;
    logic [EVT_W-1:0] sw_set, sw_clr, all_set;
    evt_vec_t         set_v;

    assign sw_set  = set_wr ? wdata : '0;
    assign sw_clr  = clr_wr ? wdata : '0;
    assign all_set = hw_set | sw_set;
    assign set_v   = evt_vec_t'(all_set);

    assign err_set_o = set_v.dovf | set_v.irde | set_v.nwrp;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            mask_q <= '0;
        end else begin
            stat_q <= (stat_q & ~sw_clr) | all_set;
            if (mset_wr) mask_q <= mask_q | wdata;
            if (mclr_wr) mask_q <= mask_q & ~wdata;
        end
    end

    assign stat_o = stat_q;
    assign mask_o = mask_q;
    assign irq_o  = |(stat_q & mask_q);

    // R6: a hardware event is recorded even when a clear arrives with it
    a_r6_hw_wins: assert property (@(posedge clk) disable iff (rst)
        (hw_set != '0) |=> ((stat_q & $past(hw_set)) == $past(hw_set)));

    // R6: a clear with no competing set removes the written bits
    a_r6_clear_works: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && hw_set == '0) |=> ((stat_q & $past(wdata)) == '0));

endmodule

// File: rtl/cmdq_fetch_fsm.sv
module cmdq_fetch_fsm
    import cmdq_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int CNT_W  = DEF_CNT_W,
    parameter int SIZE_W = DEF_SIZE_W,
    parameter int INFL_W = DEF_INFL_W,
    parameter int STEP   = INST_WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              q_ena,
    input  logic [CNT_W-1:0]  pending,
    input  logic [SIZE_W-1:0] seg_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              done,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [ADDR_W-1:0] rd_req_addr,
    output logic              rd_req_ptr,
    input  logic              rd_rsp_valid,
    input  logic              rd_rsp_err,
    input  logic [ADDR_W-1:0] rd_rsp_ptr,
    output logic              take_o,
    output logic              irde_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [INFL_W-1:0] infl_o,
    output logic              busy_o
);
    localparam logic [INFL_W-1:0] INFL_MAX = {INFL_W{1'b1}};

    fetch_state_e      state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [SIZE_W-1:0] idx_q;
    logic [INFL_W-1:0] infl_q, infl_d;
    logic [INFL_W:0]   infl_sum;
    logic              can_go, take, err_dec, ptr_ok, irde;

    assign can_go = q_ena && (pending >= CNT_W'(STEP)) && (infl_q != INFL_MAX);

    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        err_dec = 1'b0;
        ptr_ok  = 1'b0;
        irde    = 1'b0;
        case (state_q)
            F_IDLE:
                if (can_go) state_d = (idx_q >= seg_n) ? F_PTR_REQ : F_INST_REQ;
            F_INST_REQ:
                if (rd_req_ready) begin
                    take    = 1'b1;
                    state_d = F_INST_WAIT;
                end
            F_INST_WAIT:
                if (rd_rsp_valid) begin
                    state_d = F_IDLE;
                    if (rd_rsp_err) begin
                        irde    = 1'b1;
                        err_dec = 1'b1;
                    end
                end
            F_PTR_REQ:
                if (rd_req_ready) state_d = F_PTR_WAIT;
            F_PTR_WAIT:
                if (rd_rsp_valid) begin
                    state_d = F_IDLE;
                    if (rd_rsp_err) irde   = 1'b1;
                    else            ptr_ok = 1'b1;
                end
            default: state_d = F_IDLE;
        endcase
    end

    always_comb begin
        infl_sum = {1'b0, infl_q};
        if (take)    infl_sum = infl_sum + 1'b1;
        if (err_dec) infl_sum = infl_sum - 1'b1;
        if (done && infl_sum != '0) infl_sum = infl_sum - 1'b1;
        infl_d = infl_sum[INFL_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= F_IDLE;
            addr_q  <= '0;
            idx_q   <= '0;
            infl_q  <= '0;
        end else begin
            state_q <= state_d;
            infl_q  <= infl_d;
            if (cfg_wr) begin
                addr_q <= cfg_addr;
                idx_q  <= '0;
            end else if (take) begin
                addr_q <= addr_q + 1'b1;
                idx_q  <= idx_q + 1'b1;
            end else if (ptr_ok) begin
                addr_q <= rd_rsp_ptr;
                idx_q  <= '0;
            end
        end
    end

    assign rd_req_valid = (state_q == F_INST_REQ) || (state_q == F_PTR_REQ);
    assign rd_req_ptr   = (state_q == F_PTR_REQ);
    assign rd_req_addr  = addr_q;
    assign take_o       = take;
    assign irde_o       = irde;
    assign addr_o       = addr_q;
    assign infl_o       = infl_q;
    assign busy_o       = (state_q != F_IDLE);

    // R11: request held until accepted
    a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
        (rd_req_valid && !rd_req_ready) |=>
            (rd_req_valid && $stable(rd_req_addr) && $stable(rd_req_ptr)));

    // R3: an instruction request stays inside the current segment
    a_r3_inst_in_seg: assert property (@(posedge clk) disable iff (rst)
        (state_q == F_INST_REQ) |-> (idx_q < seg_n));

    // R9: the in-flight counter never wraps
    a_r9_infl_cap: assert property (@(posedge clk) disable iff (rst)
        (infl_q == INFL_MAX) |-> !take);

    // R4: a good pointer response starts the next segment
    a_r4_ptr_load: assert property (@(posedge clk) disable iff (rst)
        (state_q == F_PTR_WAIT && rd_rsp_valid && !rd_rsp_err) |=>
            (addr_q == $past(rd_rsp_ptr) && idx_q == '0));

    // R8: a failed pointer read keeps the fetch address
    a_r8_ptr_err_keep: assert property (@(posedge clk) disable iff (rst)
        (state_q == F_PTR_WAIT && rd_rsp_valid && rd_rsp_err) |=> $stable(addr_q));

endmodule

// File: rtl/cmdq_fetch_seq.sv
module cmdq_fetch_seq
    import cmdq_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int CNT_W  = DEF_CNT_W,
    parameter int SIZE_W = DEF_SIZE_W,
    parameter int INFL_W = DEF_INFL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [2:0]        reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    input  logic              hw_mbox,
    input  logic              hw_nwrp,
    input  logic              hw_swerr,
    input  logic              inst_done,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [ADDR_W-1:0] rd_req_addr,
    output logic              rd_req_ptr,
    input  logic              rd_rsp_valid,
    input  logic              rd_rsp_err,
    input  logic [ADDR_W-1:0] rd_rsp_ptr,
    output logic              q_enable,
    output logic              cont_on_err,
    output logic [CNT_W-1:0]  pending_words,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [SIZE_W-1:0] seg_words,
    output logic [INFL_W-1:0] inflight,
    output logic [EVT_W-1:0]  int_status,
    output logic [EVT_W-1:0]  int_mask,
    output logic              irq
);
    reg_sel_e          sel;
    logic              wr_ctrl, wr_dbell, wr_seg, wr_start;
    logic              wr_eclr, wr_eset, wr_mset, wr_mclr;
    logic              ena_q, cont_q;
    logic [SIZE_W-1:0] seg_q, seg_n;
    logic              cfg_ok, busy, take, irde_evt, dovf_evt, err_set;
    evt_vec_t          hw_evt;

    assign sel      = reg_sel_e'(reg_sel);
    assign wr_ctrl  = reg_wr && (sel == SEL_CTRL);
    assign wr_dbell = reg_wr && (sel == SEL_DBELL);
    assign wr_seg   = reg_wr && (sel == SEL_SEGSZ);
    assign wr_start = reg_wr && (sel == SEL_START);
    assign wr_eclr  = reg_wr && (sel == SEL_EVT_CLR);
    assign wr_eset  = reg_wr && (sel == SEL_EVT_SET);
    assign wr_mset  = reg_wr && (sel == SEL_MASK_SET);
    assign wr_mclr  = reg_wr && (sel == SEL_MASK_CLR);

    assign cfg_ok = !ena_q && (inflight == '0) && !busy;
    assign seg_n  = SIZE_W'(insts_in_seg(32'(seg_q)));

    always_ff @(posedge clk) begin
        if (rst) begin
            ena_q  <= 1'b0;
            cont_q <= 1'b0;
            seg_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                ena_q  <= reg_wdata[0];
                cont_q <= reg_wdata[1];
            end
            if (err_set && !cont_q) ena_q <= 1'b0;
            if (wr_seg && cfg_ok) seg_q <= reg_wdata[SIZE_W-1:0];
        end
    end

    always_comb begin
        hw_evt       = '0;
        hw_evt.mbox  = hw_mbox;
        hw_evt.dovf  = dovf_evt;
        hw_evt.irde  = irde_evt;
        hw_evt.nwrp  = hw_nwrp;
        hw_evt.swerr = hw_swerr;
    end

    cmdq_dbell_cnt #(.CNT_W(CNT_W), .STEP(INST_WORDS)) u_dbell (
        .clk     (clk),
        .rst     (rst),
        .add_vld (wr_dbell),
        .add_val (reg_wdata[CNT_W-1:0]),
        .take    (take),
        .cnt_o   (pending_words),
        .ovf_o   (dovf_evt)
    );

    cmdq_evt_regs u_evt (
        .clk       (clk),
        .rst       (rst),
        .hw_set    (hw_evt),
        .clr_wr    (wr_eclr),
        .set_wr    (wr_eset),
        .mset_wr   (wr_mset),
        .mclr_wr   (wr_mclr),
        .wdata     (reg_wdata[EVT_W-1:0]),
        .stat_o    (int_status),
        .mask_o    (int_mask),
        .irq_o     (irq),
        .err_set_o (err_set)
    );

    cmdq_fetch_fsm #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SIZE_W(SIZE_W),
        .INFL_W(INFL_W), .STEP(INST_WORDS)
    ) u_fetch (
        .clk          (clk),
        .rst          (rst),
        .q_ena        (ena_q),
        .pending      (pending_words),
        .seg_n        (seg_n),
        .cfg_wr       (wr_start && cfg_ok),
        .cfg_addr     (reg_wdata),
        .done         (inst_done),
        .rd_req_valid (rd_req_valid),
        .rd_req_ready (rd_req_ready),
        .rd_req_addr  (rd_req_addr),
        .rd_req_ptr   (rd_req_ptr),
        .rd_rsp_valid (rd_rsp_valid),
        .rd_rsp_err   (rd_rsp_err),
        .rd_rsp_ptr   (rd_rsp_ptr),
        .take_o       (take),
        .irde_o       (irde_evt),
        .addr_o       (fetch_addr),
        .infl_o       (inflight),
        .busy_o       (busy)
    );

    assign q_enable    = ena_q;
    assign cont_on_err = cont_q;
    assign seg_words   = seg_q;

    // R7: an error event with continue-on-error clear stops the queue
    a_r7_err_disables: assert property (@(posedge clk) disable iff (rst)
        (err_set && !cont_q) |=> !q_enable);

    // R10: segment size frozen while the queue is enabled
    a_r10_seg_locked: assert property (@(posedge clk) disable iff (rst)
        ena_q |=> $stable(seg_q));

    // R3: no fetch request begins while disabled
    a_r3_no_start_disabled: assert property (@(posedge clk) disable iff (rst)
        (!ena_q && !rd_req_valid) |=> !rd_req_valid);

endmodule

// File: tb/cmdq_fetch_seq_tb_top.sv
module cmdq_fetch_seq_tb_top;
    import cmdq_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [42:0] reg_wdata = '0;
    logic        hw_mbox = 1'b0, hw_nwrp = 1'b0, hw_swerr = 1'b0, inst_done = 1'b0;
    logic        rd_req_valid, rd_req_ptr;
    logic        rd_req_ready = 1'b0;
    logic [42:0] rd_req_addr;
    logic        rd_rsp_valid = 1'b0, rd_rsp_err = 1'b0;
    logic [42:0] rd_rsp_ptr = '0;
    logic        q_enable, cont_on_err, irq;
    logic [19:0] pending_words;
    logic [42:0] fetch_addr;
    logic [12:0] seg_words;
    logic [7:0]  inflight;
    logic [4:0]  int_status, int_mask;

    always #2 clk = ~clk;

    cmdq_fetch_seq dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .hw_mbox(hw_mbox), .hw_nwrp(hw_nwrp), .hw_swerr(hw_swerr), .inst_done(inst_done),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
        .rd_req_ptr(rd_req_ptr), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_err(rd_rsp_err),
        .rd_rsp_ptr(rd_rsp_ptr), .q_enable(q_enable), .cont_on_err(cont_on_err),
        .pending_words(pending_words), .fetch_addr(fetch_addr), .seg_words(seg_words),
        .inflight(inflight), .int_status(int_status), .int_mask(int_mask), .irq(irq)
    );

    int          n_checks = 0, n_fail = 0;
    logic [42:0] m_addr = '0;
    int          m_idx = 0, m_n = 0, m_pend = 0, m_infl = 0, chunk_k = 0;
    bit          outst = 0, inj_err = 0;
    logic [42:0] hold_addr;
    bit          hold_chk = 0;
    int unsigned seed_v;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int seg_insts(input int words);
        return (words == 0) ? 0 : (words - 1) / 8;
    endfunction

    task automatic wr(input logic [2:0] sel, input logic [42:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        if (sel == SEL_DBELL) m_pend = (m_pend + int'(d[19:0])) & 32'hFFFFF;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic settle();
        int quiet = 0;
        while (quiet < 12) begin
            @(negedge clk);
            if (!rd_req_valid && !outst && !rd_rsp_valid) quiet++;
            else quiet = 0;
        end
    endtask

    task automatic pulse_done();
        @(negedge clk); inst_done = 1'b1;
        @(negedge clk); inst_done = 1'b0;
        if (m_infl > 0) m_infl--;
    endtask

    task automatic drain_done();
        while (m_infl > 0) pulse_done();
    endtask

    task automatic pulse_evt(input int which);
        @(negedge clk);
        if (which == 0) hw_mbox = 1'b1;
        if (which == 3) hw_nwrp = 1'b1;
        if (which == 4) hw_swerr = 1'b1;
        @(negedge clk);
        hw_mbox = 1'b0; hw_nwrp = 1'b0; hw_swerr = 1'b0;
    endtask

    // memory responder and request-sequence model
    initial begin
        bit was_ptr;
        forever begin
            @(negedge clk);
            rd_rsp_valid = 1'b0; rd_rsp_err = 1'b0;
            if (hold_chk) begin
                chk("R11 valid held", rd_req_valid, 1);
                chk("R11 address held", rd_req_addr, hold_addr);
            end
            rd_req_ready = rd_req_valid && (($urandom % 3) != 0);
            hold_chk = rd_req_valid && !rd_req_ready;
            hold_addr = rd_req_addr;
            if (rd_req_ready) begin
                hold_chk = 0;
                was_ptr = rd_req_ptr;
                chk("R4 request kind", rd_req_ptr, (m_idx >= m_n));
                chk("R3 request address", rd_req_addr, m_addr);
                outst = 1;
                if (!was_ptr) begin
                    m_addr = m_addr + 1; m_idx++;
                    m_pend = (m_pend - 8) & 32'hFFFFF;
                    m_infl++;
                end
                @(negedge clk);
                rd_req_ready = 1'b0;
                repeat ($urandom % 3) @(negedge clk);
                rd_rsp_valid = 1'b1;
                rd_rsp_err = inj_err;
                rd_rsp_ptr = 43'h4000 + 43'(chunk_k * 64);
                if (was_ptr) begin
                    if (!inj_err) begin m_addr = rd_rsp_ptr; m_idx = 0; chunk_k++; end
                end else if (inj_err) m_infl--;
                inj_err = 0;
                outst = 0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        seed_v = $urandom(32'h00C0FFEE);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 q_enable", q_enable, 0);
        chk("R1 cont_on_err", cont_on_err, 0);
        chk("R1 pending", pending_words, 0);
        chk("R1 inflight", inflight, 0);
        chk("R1 status", int_status, 0);
        chk("R1 mask", int_mask, 0);
        chk("R1 irq", irq, 0);
        chk("R1 no request", rd_req_valid, 0);
        chk("R1 fetch_addr", fetch_addr, 0);

        // directed: three instructions per segment
        wr(SEL_SEGSZ, 43'd25);
        wr(SEL_START, 43'h100);
        m_n = 3; m_addr = 43'h100; m_idx = 0;
        chk("R10 start address accepted when idle", fetch_addr, 43'h100);
        chk("R10 segment size accepted when idle", seg_words, 25);
        wr(SEL_MASK_SET, 43'h1F);
        wr(SEL_CTRL, 43'h1);
        chk("R7 enable written", q_enable, 1);
        wr(SEL_DBELL, 43'd40);
        settle();
        chk("R2 pending drained", pending_words, 0);
        chk("R4 chained into next segment", fetch_addr, 43'h4002);
        chk("R9 inflight after five fetches", inflight, 5);
        chk("R6 no events", int_status, 0);
        wr(SEL_DBELL, 43'd4);
        settle();
        chk("R3 no fetch below 8 words", pending_words, 4);
        chk("R3 no fetch below 8 words inflight", inflight, 5);
        wr(SEL_DBELL, 43'd4);
        settle();
        chk("R2 pending after whole instruction", pending_words, 0);
        chk("R9 inflight", inflight, 6);
        drain_done();
        chk("R9 inflight retired", inflight, 0);
        pulse_done();
        chk("R9 done at zero ignored", inflight, 0);

        // R10: writes ignored while enabled
        wr(SEL_START, 43'h777);
        chk("R10 start ignored while enabled", fetch_addr, m_addr);
        wr(SEL_SEGSZ, 43'd9);
        chk("R10 size ignored while enabled", seg_words, 25);

        // constrained random doorbells and completions
        for (int it = 0; it < 40; it++) begin
            wr(SEL_DBELL, 43'(8 * (1 + ($urandom % 4))));
            repeat ($urandom % 6) @(negedge clk);
            if ($urandom % 2) begin
                settle();
                for (int d = 0; d < int'($urandom % 4); d++) pulse_done();
            end
        end
        settle();
        chk("R2 random pending", pending_words, 20'(m_pend));
        chk("R4 random fetch address", fetch_addr, m_addr);
        chk("R9 random inflight", inflight, 8'(m_infl));
        drain_done();

        // R5 overflow with queue off
        wr(SEL_CTRL, 43'h0);
        settle();
        chk("R2 pending before wrap", pending_words, 0);
        wr(SEL_DBELL, 43'hFFFF8);
        wr(SEL_DBELL, 43'd16);
        chk("R5 wrapped count", pending_words, 8);
        chk("R5 overflow flag", int_status[1], 1);
        chk("R6 irq from masked event", irq, 1);
        chk("R5 queue stays off", q_enable, 0);
        wr(SEL_EVT_CLR, 43'h02);
        chk("R6 write-1-clear", int_status, 0);
        chk("R6 irq drops", irq, 0);

        // R7 error events and the enable
        wr(SEL_CTRL, 43'h1);
        settle();
        pulse_evt(3);
        chk("R7 hw result error disables", q_enable, 0);
        chk("R7 result error bit3", int_status[3], 1);
        wr(SEL_EVT_CLR, 43'h1F);
        wr(SEL_CTRL, 43'h1);
        wr(SEL_EVT_SET, 43'h04);
        chk("R7 software set disables", q_enable, 0);
        chk("R6 write-1-set bit2", int_status, 5'h04);
        wr(SEL_EVT_CLR, 43'h1F);
        wr(SEL_CTRL, 43'h3);
        pulse_evt(3);
        chk("R7 continue-on-error keeps enable", q_enable, 1);
        chk("R7 bit3 still recorded", int_status[3], 1);
        wr(SEL_EVT_CLR, 43'h1F);
        wr(SEL_CTRL, 43'h1);
        pulse_evt(4);
        chk("R7 swerr does not disable", q_enable, 1);
        pulse_evt(0);
        chk("R7 mbox does not disable", q_enable, 1);
        wr(SEL_EVT_CLR, 43'h1F);
        // R6 hardware event beats same-cycle clear
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = SEL_EVT_CLR; reg_wdata = 43'h01; hw_mbox = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; hw_mbox = 1'b0;
        chk("R6 set wins over clear", int_status[0], 1);
        wr(SEL_MASK_CLR, 43'h01);
        chk("R6 mask cleared", int_mask, 5'h1E);
        chk("R6 masked bit gives no irq", irq, 0);
        wr(SEL_MASK_SET, 43'h01);
        chk("R6 unmasked bit gives irq", irq, 1);
        wr(SEL_EVT_CLR, 43'h1F);

        // R8 error on next read response
        settle();
        inj_err = 1;
        wr(SEL_DBELL, 43'd8);
        settle();
        chk("R8 read error flag", int_status[2], 1);
        chk("R7 read error disables", q_enable, 0);
        chk("R8 inflight after error", inflight, 8'(m_infl));
        chk("R2 pending after error", pending_words, 20'(m_pend));

        // R8 failed pointer read
        wr(SEL_EVT_CLR, 43'h1F);
        drain_done();
        m_pend = 0;
        chk("R2 pending clear before pointer test", pending_words, 0);
        wr(SEL_SEGSZ, 43'd9);
        wr(SEL_START, 43'h200);
        m_n = 1; m_addr = 43'h200; m_idx = 0;
        chk("R10 size accepted when quiescent", seg_words, 9);
        wr(SEL_CTRL, 43'h1);
        wr(SEL_DBELL, 43'd8);
        settle();
        inj_err = 1;
        wr(SEL_DBELL, 43'd8);
        settle();
        chk("R8 pointer error keeps address", fetch_addr, 43'h201);
        chk("R8 pointer error flag", int_status[2], 1);
        chk("R8 pointer error pending kept", pending_words, 8);
        wr(SEL_START, 43'h999);
        chk("R10 start ignored while inflight nonzero", fetch_addr, 43'h201);
        wr(SEL_EVT_CLR, 43'h1F);
        wr(SEL_CTRL, 43'h1);
        settle();
        chk("R4 pointer retried and followed", fetch_addr, m_addr);
        chk("R2 pending consumed after retry", pending_words, 0);
        chk("R9 inflight after retry", inflight, 8'(m_infl));

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule